// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block drives an I2C bus as a controller, one byte at a time, under the control of a small register file. Software loads an outgoing byte into a shared buffer register. It then writes one or more command bits: begin a transfer, send a byte, receive a byte (optionally refusing it with a NACK), or end the transfer. The engine runs the queued phases in a fixed order: start first, then transmit, then receive, then stop. Each command bit clears itself when its phase is done. A received byte shows up in the upper half of the buffer's low 16 bits.

Each finished step, and each error, sets a sticky status bit. Software clears a status bit by writing one to it. An enable register with the same bit layout selects which status bits raise the interrupt. Bit timing is paced by a `tick` input: each SCL bit period takes four ticks. Both lines are open-drain. An `_oe` output of one pulls the line low.

There are four registers, selected by `reg_addr`:
- index 0: command, with read-only line status
- index 1: byte buffer
- index 2: interrupt enable
- index 3: interrupt status

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, every command bit and every status bit is zero, both `scl_oe` and `sda_oe` are low, `irq` is low, and register 0 reads back 0x0006_0000 on an idle bus (both lines high, not busy).
- R2: Writing command bits 0 (start) and 1 (transmit) together does three things in order. It produces a start condition. It sends buffer bits 7:0, MSB first. It samples the ACK slot. An ACK sets status bit 0, and command bits 0 and 1 then read back zero.
- R3: A NACK on a transmitted byte sets status bit 1. It also clears any queued start, receive and receive-last bits (0, 3, 4), but a queued stop (bit 5) still runs.
- R4: Command bit 3 (receive) clocks in one byte, MSB first, places it in buffer bits 15:8 and sets status bit 2. In the ACK slot the engine drives SDA low, unless bit 4 (receive-last) is set. With bit 4 set it leaves SDA released, which sends a NACK. Bits 3 and 4 then clear.
- R5: Command bit 5 (stop) produces a stop condition, releases both lines and sets status bit 4.
- R6: Several command bits written at once run in the order start, transmit, receive, stop. This happens within a single write.
- R7: If the engine releases SDA during an address or data bit and samples it low, arbitration is lost. The engine sets status bit 3, clears all command bits and releases both lines.
- R8: If SCL stays low for `TMO_TICKS` ticks after the engine released it, the engine sets status bit 6, clears all command bits and releases both lines.
- R9: A transmit, receive or stop command issued while the engine does not own the bus is dropped. It sets status bit 5 (abnormal), and no line is driven.
- R10: Writing register 3 clears exactly the status bits written as one; other bits, including receive-done, are kept. `irq` is high when a status bit and its enable bit (register 2, same positions) are both set.
- R11: Register 0 gives bus busy in bit 16, the SDA level in bit 17 and the SCL level in bit 18. Busy sets on any start condition seen on the bus and clears on a stop condition.
- R12: A start command waits, without driving either line, while another controller keeps the bus busy. It proceeds once a stop condition is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Quarter-bit pacing strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 command, 1 buffer, 2 enable, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Interrupt request |

## Verification
The bench models an I2C target that ACKs or NACKs addresses and data at random, serves read bytes and logs the controller's own ACK bits. It checks the following corner cases:
- A read whose address is NACKed: a design that kept the receive queued would clock bytes from a target that is not answering.
- A two-byte read: a design that got the receive-last handling wrong would NACK the first byte or ACK the last one. The target would then keep SDA low through the stop.
- Arbitration loss and an SCL held low: a design that kept its command bits would resume driving after the error.
- A start issued while another controller holds the bus: a design that ignored busy would pull SCL in the middle of someone else's transfer.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
    localparam int CMD_W  = 6;
    localparam int C_START = 0;
    localparam int C_TX    = 1;
    localparam int C_RX    = 3;
    localparam int C_LAST  = 4;
    localparam int C_STOP  = 5;
    localparam logic [CMD_W-1:0] CMD_MASK = 6'b111011;

    localparam int STS_W   = 15;
    localparam int S_ACK   = 0;
    localparam int S_NAK   = 1;
    localparam int S_RXD   = 2;
    localparam int S_ARB   = 3;
    localparam int S_STOP  = 4;
    localparam int S_ABN   = 5;
    localparam int S_SCLTO = 6;
    localparam logic [STS_W-1:0] STS_MASK = 15'h007F;

    localparam int L_BUSY = 16;
    localparam int L_SDA  = 17;
    localparam int L_SCL  = 18;

    localparam logic [1:0] A_CMD = 2'd0;
    localparam logic [1:0] A_BUF = 2'd1;
    localparam logic [1:0] A_IEN = 2'd2;
    localparam logic [1:0] A_STS = 2'd3;

    typedef enum logic [1:0] {ENG_IDLE, ENG_START, ENG_BYTE, ENG_STOP} eng_e;
endpackage

// File: rtl/i2c_bm_busmon.sv
module i2c_bm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy
);
    typedef struct packed {
        logic scl;
        logic sda;
        logic busy;
    } mon_t;

    mon_t m_d, m_q;
    logic start_seen, stop_seen;

    always_comb begin
        m_d        = m_q;
        m_d.scl    = scl_i;
        m_d.sda    = sda_i;
        start_seen = m_q.scl && scl_i && m_q.sda && !sda_i;
        stop_seen  = m_q.scl && scl_i && !m_q.sda && sda_i;
        if (start_seen)     m_d.busy = 1'b1;
        else if (stop_seen) m_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{scl: 1'b1, sda: 1'b1, busy: 1'b0};
        else        m_q <= m_d;
    end

    assign busy = m_q.busy;

    // R11: a start condition on the wires marks the bus busy
    assert_busy_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> busy);
    // R11: a stop condition frees the bus
    assert_free_on_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !busy);
endmodule

// File: rtl/i2c_bm_irq.sv
module i2c_bm_irq #(
    parameter int              W    = 15,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         ien_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] sts,
    output logic [W-1:0] ien,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] sts;
        logic [W-1:0] ien;
    } irq_t;

    irq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ien_we) r_d.ien = wdata & MASK;
        if (clr_we) r_d.sts = r_q.sts & ~wdata;
        r_d.sts = r_d.sts | (set & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sts = r_q.sts;
    assign ien = r_q.ien;
    assign irq = |(r_q.sts & r_q.ien);

    // R10: a write-one clear removes the bit unless a new event sets it again
    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((sts & $past(wdata & ~set)) == '0));
    // R10: with every enable off the request stays low
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int TMO_TICKS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        irq
);
    localparam int TMO_W = $clog2(TMO_TICKS + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_TICKS - 1);

    typedef struct packed {
        eng_e             st;
        logic [1:0]       ph;
        logic [3:0]       bitn;
        logic [7:0]       sh;
        logic             rx;
        logic             nak;
        logic [CMD_W-1:0] cmd;
        logic [7:0]       txb;
        logic [7:0]       rxb;
        logic             own;
        logic             scl_lo;
        logic             sda_lo;
        logic [TMO_W-1:0] tmo;
    } eng_t;

    eng_t d, q;
    logic [STS_W-1:0] ev, sts, ien;
    logic busy, arb_err, to_err, scl_up;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[31:STS_W];

    i2c_bm_busmon u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .busy(busy)
    );

    i2c_bm_irq #(.W(STS_W), .MASK(STS_MASK)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(ev),
        .ien_we(reg_we && reg_addr == A_IEN),
        .clr_we(reg_we && reg_addr == A_STS),
        .wdata(reg_wdata[STS_W-1:0]),
        .sts(sts), .ien(ien), .irq(irq)
    );

    always_comb begin
        d       = q;
        ev      = '0;
        arb_err = 1'b0;
        to_err  = 1'b0;
        scl_up  = 1'b0;
        if (reg_we && reg_addr == A_CMD)
            d.cmd = q.cmd | (reg_wdata[CMD_W-1:0] & CMD_MASK);
        if (reg_we && reg_addr == A_BUF)
            d.txb = reg_wdata[7:0];

        // phases that wait for a released SCL to come high
        if (tick && ((q.st == ENG_START && q.ph == 2'd1) ||
                     (q.st != ENG_START && q.st != ENG_IDLE && q.ph == 2'd2))) begin
            if (scl_i) begin
                scl_up = 1'b1;
                d.tmo  = '0;
            end else if (q.tmo == TMO_LAST) begin
                to_err = 1'b1;
            end else begin
                d.tmo = q.tmo + 1'b1;
            end
        end

        case (q.st)
            ENG_IDLE: begin
                if (q.cmd[C_START]) begin
                    if (!busy || q.own) begin
                        d.st     = ENG_START;
                        d.ph     = 2'd0;
                        d.sda_lo = 1'b0;
                    end
                end else if (q.cmd[C_TX] || q.cmd[C_RX]) begin
                    if (q.own) begin
                        d.st   = ENG_BYTE;
                        d.ph   = 2'd0;
                        d.bitn = 4'd0;
                        d.rx   = !q.cmd[C_TX];
                        d.sh   = q.txb;
                    end else begin
                        d.cmd[C_TX]   = 1'b0;
                        d.cmd[C_RX]   = 1'b0;
                        d.cmd[C_LAST] = 1'b0;
                        ev[S_ABN]     = 1'b1;
                    end
                end else if (q.cmd[C_STOP]) begin
                    if (q.own) begin
                        d.st = ENG_STOP;
                        d.ph = 2'd0;
                    end else begin
                        d.cmd[C_STOP] = 1'b0;
                        ev[S_ABN]     = 1'b1;
                    end
                end
            end
            ENG_START: begin
                if (tick) begin
                    case (q.ph)
                        2'd0: begin d.scl_lo = 1'b0; d.ph = 2'd1; end
                        2'd1: if (scl_up) begin d.sda_lo = 1'b1; d.ph = 2'd2; end
                        default: begin
                            d.scl_lo       = 1'b1;
                            d.own          = 1'b1;
                            d.cmd[C_START] = 1'b0;
                            d.st           = ENG_IDLE;
                        end
                    endcase
                end
            end
            ENG_BYTE: begin
                if (tick) begin
                    case (q.ph)
                        2'd0: begin
                            if (q.bitn == 4'd8) d.sda_lo = q.rx && !q.cmd[C_LAST];
                            else                d.sda_lo = !q.rx && !q.sh[7];
                            d.ph = 2'd1;
                        end
                        2'd1: begin d.scl_lo = 1'b0; d.ph = 2'd2; end
                        2'd2: if (scl_up) begin
                            if (q.bitn == 4'd8) begin
                                d.nak = sda_i;
                            end else begin
                                arb_err = !q.rx && q.sh[7] && !sda_i;
                                d.sh    = {q.sh[6:0], sda_i};
                            end
                            d.ph = 2'd3;
                        end
                        default: begin
                            d.scl_lo = 1'b1;
                            if (q.bitn == 4'd8) begin
                                d.st = ENG_IDLE;
                                if (q.rx) begin
                                    d.rxb         = q.sh;
                                    ev[S_RXD]     = 1'b1;
                                    d.cmd[C_RX]   = 1'b0;
                                    d.cmd[C_LAST] = 1'b0;
                                end else begin
                                    d.cmd[C_TX] = 1'b0;
                                    if (q.nak) begin
                                        ev[S_NAK]      = 1'b1;
                                        d.cmd[C_START] = 1'b0;
                                        d.cmd[C_RX]    = 1'b0;
                                        d.cmd[C_LAST]  = 1'b0;
                                    end else begin
                                        ev[S_ACK] = 1'b1;
                                    end
                                end
                            end else begin
                                d.bitn = q.bitn + 4'd1;
                                d.ph   = 2'd0;
                            end
                        end
                    endcase
                end
            end
            default: begin // ENG_STOP
                if (tick) begin
                    case (q.ph)
                        2'd0: begin d.sda_lo = 1'b1; d.ph = 2'd1; end
                        2'd1: begin d.scl_lo = 1'b0; d.ph = 2'd2; end
                        default: if (scl_up) begin
                            d.sda_lo      = 1'b0;
                            d.own         = 1'b0;
                            d.cmd[C_STOP] = 1'b0;
                            d.st          = ENG_IDLE;
                            ev[S_STOP]    = 1'b1;
                        end
                    endcase
                end
            end
        endcase

        if (arb_err || to_err) begin
            d.st       = ENG_IDLE;
            d.ph       = 2'd0;
            d.cmd      = '0;
            d.own      = 1'b0;
            d.scl_lo   = 1'b0;
            d.sda_lo   = 1'b0;
            d.tmo      = '0;
            ev[S_ARB]   = arb_err;
            ev[S_SCLTO] = to_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ENG_IDLE, default: '0};
        else        q <= d;
    end

    assign scl_oe = q.scl_lo;
    assign sda_oe = q.sda_lo;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CMD: begin
                reg_rdata[CMD_W-1:0] = q.cmd;
                reg_rdata[L_BUSY]    = busy;
                reg_rdata[L_SDA]     = sda_i;
                reg_rdata[L_SCL]     = scl_i;
            end
            A_BUF:   reg_rdata = {16'h0, q.rxb, q.txb};
            A_IEN:   reg_rdata = {{(32-STS_W){1'b0}}, ien};
            default: reg_rdata = {{(32-STS_W){1'b0}}, sts};
        endcase
    end

    // R9: without bus ownership an idle engine drives neither line
    assert_idle_unowned_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ENG_IDLE && !q.own) |-> (!scl_oe && !sda_oe));
    // R2: SDA never moves under the engine while SCL stays high inside a byte
    assert_sda_steady_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ENG_BYTE && $past(q.st) == ENG_BYTE && scl_i && $past(scl_i))
        |-> $stable(sda_oe));
    // R2: byte results are only reported while the bus is owned
    assert_result_when_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[S_ACK] || ev[S_NAK] || ev[S_RXD]) |-> q.own);
    // R7: a new arbitration-loss report comes with lines released and queue empty
    assert_arb_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[S_ARB]) |-> (!scl_oe && !sda_oe && !q.own && q.cmd == '0));
    // R8: a new SCL timeout report comes with lines released and queue empty
    assert_tmo_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[S_SCLTO]) |-> (!scl_oe && !sda_oe && !q.own && q.cmd == '0));
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl_oe, sda_oe, irq;
    logic        scl_line, sda_line;
    logic        s_low = 1'b0, tb_sda_low = 1'b0, tb_scl_hold = 1'b0;

    int n_tests = 0, n_fail = 0, cycles = 0;
    logic [1:0] tdiv = 2'd0;

    assign scl_line = !(scl_oe === 1'b1 || tb_scl_hold);
    assign sda_line = !(sda_oe === 1'b1 || s_low || tb_sda_low);

    i2c_byte_master u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd2);
    end

    // target model
    bit m_rd = 0, ack_addr = 1, ack_data = 1, active = 0, rd_done = 0;
    int cnt = 0, byte_i = 0, starts = 0;
    logic [7:0] d0 = 0, d1 = 0, cap = 0, cap_addr = 0, cap_data = 0;
    logic [1:0] mack = 0;

    function automatic bit rd_byte();
        return m_rd && ack_addr && byte_i > 0;
    endfunction

    always @(negedge sda_line) if (rst_n && scl_line) begin
        active = 1; cnt = -1; byte_i = 0; s_low = 0; rd_done = 0; starts++;
    end
    always @(posedge sda_line) if (rst_n && scl_line) begin
        active = 0; s_low = 0;
    end
    always @(negedge scl_line) if (rst_n && active) begin
        cnt++;
        if (cnt == 9) begin cnt = 0; byte_i++; end
        if (cnt < 8) s_low = rd_byte() && !rd_done && !((byte_i == 1 ? d0 : d1) >> (7 - cnt) & 1);
        else         s_low = !rd_byte() && (byte_i == 0 ? ack_addr : ack_data);
    end
    always @(posedge scl_line) if (rst_n && active) begin
        if (cnt >= 0 && cnt < 8 && !rd_byte()) begin
            cap = {cap[6:0], sda_line};
            if (cnt == 7) begin
                if (byte_i == 0) cap_addr = cap; else cap_data = cap;
            end
        end
        if (cnt == 8 && rd_byte()) begin
            mack = {mack[0], !sda_line};
            if (sda_line) rd_done = 1;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, cycles=%0d expected<150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 3000; k++) begin
            rd(2'd0, v);
            if (v[5:0] == 0) return;
        end
    endtask

    function automatic logic [31:0] ack_bit(input bit a);
        return a ? 32'h1 : 32'h2;
    endfunction

    localparam logic [31:0] ST_RXD = 32'h4, ST_ARB = 32'h8, ST_STOP = 32'h10,
                            ST_ABN = 32'h20, ST_TO = 32'h40;

    task automatic free_bus();
        @(negedge clk); tb_sda_low = 1;
        repeat (8) @(negedge clk);
        tb_sda_low = 0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, e;
        logic [6:0] a7;
        int n, s0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);

        // reset state
        rd(2'd0, v); chk(v == 32'h0006_0000, "R1 cmd/line readback", v, 32'h0006_0000);
        rd(2'd3, v); chk(v == 0, "R1 status", v, 0);
        chk({scl_oe, sda_oe, irq} == 3'b000, "R1 outputs", {29'b0, scl_oe, sda_oe, irq}, 0);

        wr(2'd2, ST_RXD);   // enable only receive-done

        // transmit without ownership
        wr(2'd0, 32'h2); wait_idle();
        rd(2'd3, v); chk(v == ST_ABN, "R9 abnormal status", v, ST_ABN);
        rd(2'd0, v); chk(v[5:0] == 0 && !scl_oe && !sda_oe, "R9 dropped, lines free", v, 32'h0006_0000);
        wr(2'd3, 32'h7FFF);

        // random transactions
        for (int i = 0; i < 24; i++) begin
            a7 = 7'($urandom); m_rd = 1'($urandom); n = 1 + int'($urandom % 2);
            ack_addr = ($urandom % 4) != 0; ack_data = 1'($urandom);
            d0 = 8'($urandom); d1 = 8'($urandom); mack = 0;
            s0 = starts;
            wr(2'd1, {24'h0, a7, m_rd});
            if (m_rd) begin
                wr(2'd0, n == 1 ? 32'h3B : 32'h0B); wait_idle();
                chk(starts == s0 + 1, "R2 start seen", starts, s0 + 1);
                chk(cap_addr == {a7, m_rd}, "R2 address sent", cap_addr, {a7, m_rd});
                rd(2'd3, v);
                if (!ack_addr) begin
                    e = ack_bit(0) | (n == 1 ? ST_STOP : 0);
                    chk(v == e, "R3 nak drops receive", v, e);
                    chk(irq == 0, "R10 irq masked", irq, 0);
                    wr(2'd3, 32'h7FFF);
                    if (n == 2) begin
                        wr(2'd0, 32'h20); wait_idle();
                        rd(2'd3, v); chk(v == ST_STOP, "R3 stop survives nak", v, ST_STOP);
                    end
                end else if (n == 1) begin
                    e = ack_bit(1) | ST_RXD | ST_STOP;
                    chk(v == e, "R6 start-tx-rx-stop status", v, e);
                    rd(2'd1, v); chk(v[15:8] == d0, "R4 rx byte", v[15:8], d0);
                    chk(mack[0] == 0, "R4 last byte nacked", mack, 0);
                end else begin
                    e = ack_bit(1) | ST_RXD;
                    chk(v == e, "R4 first rx status", v, e);
                    chk(irq == 1, "R10 irq on rx-done", irq, 1);
                    rd(2'd1, v); chk(v[15:8] == d0, "R4 first rx byte", v[15:8], d0);
                    wr(2'd3, ST_RXD);
                    rd(2'd3, v); chk(v == ack_bit(1), "R10 separate rx-done clear", v, ack_bit(1));
                    chk(irq == 0, "R10 irq drops", irq, 0);
                    wr(2'd3, 32'h7FFF);
                    wr(2'd0, 32'h38); wait_idle();
                    rd(2'd3, v); e = ST_RXD | ST_STOP;
                    chk(v == e, "R5 rx-last then stop", v, e);
                    rd(2'd1, v); chk(v[15:8] == d1, "R4 second rx byte", v[15:8], d1);
                    chk(mack == 2'b10, "R4 ack then nack", mack, 2'b10);
                end
            end else begin
                wr(2'd0, 32'h03); wait_idle();
                chk(cap_addr == {a7, 1'b0}, "R2 address sent", cap_addr, {a7, 1'b0});
                rd(2'd3, v); chk(v == ack_bit(ack_addr), "R2 address ack/nak", v, ack_bit(ack_addr));
                rd(2'd0, v); chk(v[1:0] == 0, "R2 command bits self-clear", v, 0);
                wr(2'd3, 32'h7FFF);
                if (ack_addr) begin
                    wr(2'd1, {24'h0, d0});
                    wr(2'd0, 32'h22); wait_idle();
                    chk(cap_data == d0, "R2 data byte sent", cap_data, d0);
                    rd(2'd3, v); e = ack_bit(ack_data) | ST_STOP;
                    chk(v == e, "R5 data then stop", v, e);
                end else begin
                    wr(2'd0, 32'h20); wait_idle();
                    rd(2'd3, v); chk(v == ST_STOP, "R5 stop", v, ST_STOP);
                end
            end
            chk(!scl_oe && !sda_oe, "R5 lines released", {scl_oe, sda_oe}, 0);
            rd(2'd0, v); chk(v[L_BUSY_IDX] == 0, "R11 busy clears on stop", v, 32'h0006_0000);
            wr(2'd3, 32'h7FFF);
        end

        // arbitration loss
        m_rd = 0; ack_addr = 1;
        wr(2'd0, 32'h1); wait_idle();
        tb_sda_low = 1;
        wr(2'd1, 32'hA5); wr(2'd0, 32'h22); wait_idle();
        rd(2'd3, v); chk(v == ST_ARB, "R7 arbitration status", v, ST_ARB);
        rd(2'd0, v); chk(v[5:0] == 0, "R7 queue cleared", v, 0);
        chk(!scl_oe && !sda_oe, "R7 lines released", {scl_oe, sda_oe}, 0);
        tb_sda_low = 0; repeat (8) @(negedge clk);
        wr(2'd3, 32'h7FFF);

        // SCL held low
        wr(2'd0, 32'h1); wait_idle();
        tb_scl_hold = 1;
        wr(2'd0, 32'h22); wait_idle();
        rd(2'd3, v); chk(v == ST_TO, "R8 scl timeout status", v, ST_TO);
        rd(2'd0, v); chk(v[5:0] == 0, "R8 queue cleared", v, 0);
        chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
        tb_scl_hold = 0; repeat (8) @(negedge clk);
        free_bus();
        wr(2'd3, 32'h7FFF);

        // another controller holds the bus
        @(negedge clk); tb_sda_low = 1; repeat (8) @(negedge clk);
        rd(2'd0, v); chk(v[L_BUSY_IDX] == 1 && v[17] == 0, "R11 busy on foreign start", v, 32'h0005_0000);
        wr(2'd0, 32'h1);
        repeat (200) @(negedge clk);
        rd(2'd0, v); chk(v[0] == 1, "R12 start held while busy", v, 1);
        chk(!scl_oe && !sda_oe, "R12 no drive while busy", {scl_oe, sda_oe}, 0);
        tb_sda_low = 0;
        wait_idle();
        rd(2'd0, v); chk(v[0] == 0 && v[L_BUSY_IDX] == 1, "R12 start after stop", v, 32'h1_0000);
        wr(2'd0, 32'h20); wait_idle();
        rd(2'd3, v); chk(v == ST_STOP, "R5 stop after own start", v, ST_STOP);

        summary();
        $finish;
    end

    localparam int L_BUSY_IDX = 16;
endmodule